// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block is the external bus engine of a small 8-bit processor with a 16-bit address space. A requester hands it one bus operation at a time, which is one of these:

- instruction byte fetch
- memory read
- memory write
- port read
- port write

The block then steps through a fixed series of T-states. It drives the upper address byte and a shared low-address/data bus with its own output enable. It also drives an address-latch pulse, active-low read and write strobes, and three status lines: a memory-or-port select and two cycle-kind bits.

The low address byte and the data byte share the same eight wires. In the first T-state the address is on them and the latch pulse is high, so that outside logic can hold the byte. After that the wires carry data. Read bytes are captured at the end of the third T-state. A fetched byte is also loaded into a separate instruction output. A fetch adds one internal T-state with no strobe, during which decode can happen.

A one-cycle done pulse marks the final T-state of every operation. A new request may be taken in that same cycle, so operations can run back to back. Each one still starts with its own address phase.

Top module: `mcyc_bus_seq`

## Requirements
- R1: After reset and while idle: rd_n=1, wr_n=1, ale=0, ad_oe=0, done=0, req_ready=1, and {io_m,s1,s0}=000.
- R2: In T1, the first cycle after a request is accepted: ale=1, ad_oe=1, ad_out holds the low address byte, addr_hi holds the high address byte, and both strobes are high. ale is high in no other T-state.
- R3: {io_m,s1,s0} is 011 for a fetch, 010 for a memory read, 001 for a memory write, 110 for a port read and 101 for a port write. The value appears in T1 and stays unchanged until the last T-state. The request kind codes are fetch=0, memory read=1, memory write=2, port read=3, port write=4.
- R4: A fetch, memory read or port read holds rd_n low and wr_n high in T2 and T3, with ad_oe low from T2 onward.
- R5: A memory write or port write holds wr_n low and rd_n high in T2 and T3, with ad_oe=1 and ad_out equal to the write byte.
- R6: The ad_in byte present during T3 of any read kind appears on rdata from the next cycle. Only a fetch also updates instr; other reads leave instr unchanged.
- R7: A fetch has a fourth T-state, T4, with both strobes high, ad_oe=0, and done=1.
- R8: Memory and port cycles last exactly three T-states. done is high only in T3, and done is never high for two cycles in a row.
- R9: In a port cycle, the port number (req_addr[7:0]) appears on both addr_hi and the T1 value of ad_out.
- R10: A request is accepted only when req_ready is high, which happens in idle or in the done cycle. A request held only during T1 to T2 has no effect. A request accepted in the done cycle starts a new T1 with ale in the very next cycle.
- R11: Request kind codes 5, 6 and 7 are never accepted. The block stays idle with ale=0.
- R12: Synchronous active-high reset taken in any T-state returns all outputs to the idle values of R1 at the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Operation code (see R3) |
| req_addr | input | 16 | Memory address, or port number in bits 7:0 |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | A request is taken in this cycle if valid |
| done | output | 1 | Final T-state of the current operation |
| rdata | output | 8 | Last byte read |
| instr | output | 8 | Last fetched instruction byte |
| addr_hi | output | 8 | Upper address pins |
| ad_out | output | 8 | Shared bus, driven value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus, sampled value |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 = port space, 0 = memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |

## Verification
A T-state counter that slips shows up in the very next cycle. It either cuts a strobe short, leaves the latch pulse high in T2, or moves the done pulse one cycle away from T3 (or T4 for a fetch). A wrongly latched cycle kind is visible already in T1 on the status lines, and from T2 on the strobe polarity and the bus enable. A bad capture is seen only at rdata or instr on the cycle after the last bus T-state. For this reason every read is followed by a check of both outputs.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_MRD   = 3'd1,
    CYC_MWR   = 3'd2,
    CYC_IORD  = 3'd3,
    CYC_IOWR  = 3'd4
  } cyc_kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } tstate_e;

  function automatic logic kind_ok(input logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic kind_is_io(input cyc_kind_e k);
    return (k == CYC_IORD) || (k == CYC_IOWR);
  endfunction

  function automatic logic kind_is_read(input cyc_kind_e k);
    return (k == CYC_FETCH) || (k == CYC_MRD) || (k == CYC_IORD);
  endfunction

  // status word {io_m, s1, s0}
  function automatic logic [2:0] kind_status(input cyc_kind_e k);
    logic [2:0] st;
    case (k)
      CYC_FETCH: st = 3'b011;
      CYC_MRD:   st = 3'b010;
      CYC_MWR:   st = 3'b001;
      CYC_IORD:  st = 3'b110;
      CYC_IOWR:  st = 3'b101;
      default:   st = 3'b000;
    endcase
    return st;
  endfunction

endpackage

// File: rtl/mcyc_tstate_seq.sv
module mcyc_tstate_seq
  import mcyc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  logic    req_kind_ok,
  input  logic    cur_fetch,
  output tstate_e tstate,
  output logic    accept,
  output logic    ready,
  output logic    done
);
  tstate_e nxt;

  always_comb begin
    done   = ((tstate == TS_T3) && !cur_fetch) || (tstate == TS_T4);
    ready  = (tstate == TS_IDLE) || done;
    accept = req_valid && req_kind_ok && ready;
  end

  always_comb begin
    case (tstate)
      TS_IDLE: nxt = accept ? TS_T1 : TS_IDLE;
      TS_T1:   nxt = TS_T2;
      TS_T2:   nxt = TS_T3;
      TS_T3:   nxt = cur_fetch ? TS_T4 : (accept ? TS_T1 : TS_IDLE);
      TS_T4:   nxt = accept ? TS_T1 : TS_IDLE;
      default: nxt = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tstate <= TS_IDLE;
    else     tstate <= nxt;
  end
endmodule

// File: rtl/mcyc_req_latch.sv
module mcyc_req_latch
  import mcyc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output cyc_kind_e         kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  localparam int HI_W = ADDR_W - DATA_W;

  cyc_kind_e         kind_in;
  logic [ADDR_W-1:0] eff_addr;
  logic [HI_W-1:0]   port_hi;

  assign kind_in = cyc_kind_e'(req_kind);

  // port number repeated across the upper address bits
  genvar gi;
  generate
    for (gi = 0; gi < HI_W; gi++) begin : g_port_copy
      assign port_hi[gi] = req_addr[gi % DATA_W];
    end
  endgenerate

  assign eff_addr = kind_is_io(kind_in) ? {port_hi, req_addr[DATA_W-1:0]} : req_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q  <= CYC_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      kind_q  <= kind_in;
      addr_q  <= eff_addr;
      wdata_q <= req_wdata;
    end
  end
endmodule

// File: rtl/mcyc_pin_drive.sv
module mcyc_pin_drive
  import mcyc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  tstate_e                  tstate,
  input  cyc_kind_e                kind_q,
  input  logic [ADDR_W-1:0]        addr_q,
  input  logic [DATA_W-1:0]        wdata_q,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [2:0]               status
);
  logic busy, strobe_win, is_rd;

  always_comb begin
    busy       = (tstate != TS_IDLE);
    strobe_win = (tstate == TS_T2) || (tstate == TS_T3);
    is_rd      = kind_is_read(kind_q);
    ale        = (tstate == TS_T1);
    ad_oe      = ale || (strobe_win && !is_rd);
    ad_out     = ale ? addr_q[DATA_W-1:0] : (ad_oe ? wdata_q : '0);
    rd_n       = !(strobe_win && is_rd);
    wr_n       = !(strobe_win && !is_rd);
    status     = busy ? kind_status(kind_q) : 3'b000;
    addr_hi    = busy ? addr_q[ADDR_W-1:DATA_W] : '0;
  end
endmodule

// File: rtl/mcyc_rd_capture.sv
module mcyc_rd_capture
  import mcyc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  tstate_e           tstate,
  input  cyc_kind_e         kind_q,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] instr
);
  logic cap_now;
  assign cap_now = (tstate == TS_T3) && kind_is_read(kind_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      instr <= '0;
    end else if (cap_now) begin
      rdata <= ad_in;
      if (kind_q == CYC_FETCH) instr <= ad_in;
    end
  end
endmodule

// File: rtl/mcyc_bus_seq.sv
module mcyc_bus_seq
  import mcyc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] instr,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0
);
  tstate_e           t_state;
  cyc_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept_w;
  logic              cur_fetch_w;
  logic [2:0]        status_w;

  assign cur_fetch_w = (kind_q == CYC_FETCH);
  assign {io_m, s1, s0} = status_w;

  mcyc_tstate_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .req_kind_ok(kind_ok(req_kind)), .cur_fetch(cur_fetch_w),
    .tstate(t_state), .accept(accept_w), .ready(req_ready), .done(done)
  );

  mcyc_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .accept(accept_w), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .kind_q(kind_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  mcyc_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .tstate(t_state), .kind_q(kind_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .status(status_w)
  );

  mcyc_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .tstate(t_state), .kind_q(kind_q),
    .ad_in(ad_in), .rdata(rdata), .instr(instr)
  );
endmodule

// File: rtl/mcyc_bus_seq_chk.sv
module mcyc_bus_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic       ad_oe,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic [2:0] status,
  input logic [2:0] tstate
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q === 1'b1)
      assert_reset_idle_R12: assert (rd_n && wr_n && !ale && !ad_oe && !done)
        else $error("reset did not return pins to idle");
  end

  assert_ale_addr_phase_R2: assert property (@(posedge clk) disable iff (rst)
    ale |-> (ad_oe && rd_n && wr_n));

  assert_ale_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    ale |-> $past(req_valid && req_ready));

  assert_status_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (tstate >= 3'd2 && tstate <= 3'd4) |-> $stable(status));

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  assert_read_release_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);

  assert_write_drive_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_fetch_t4_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (done && status == 3'b011) |-> (rd_n && wr_n && !ad_oe));
endmodule

bind mcyc_bus_seq mcyc_bus_seq_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .status(status_w), .tstate(t_state)
);

// File: tb/mcyc_bus_seq_bench.sv
module mcyc_bus_seq_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, done;
  logic [7:0]  rdata, instr, addr_hi, ad_out, ad_in;
  logic        ad_oe, ale, rd_n, wr_n, io_m, s1, s0;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] last_instr = 8'h00;

  always #4 clk = ~clk;

  mcyc_bus_seq u_mcyc_bus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .instr(instr), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_status(input logic [2:0] k);
    case (k)
      3'd0: return 3'b011;
      3'd1: return 3'b010;
      3'd2: return 3'b001;
      3'd3: return 3'b110;
      default: return 3'b101;
    endcase
  endfunction

  task automatic check_idle(input string tag);
    logic [7:0] got;
    got = {rd_n, wr_n, ale, ad_oe, done, req_ready, io_m, s1};
    chk(rd_n && wr_n && !ale && !ad_oe && !done && req_ready && {io_m, s1, s0} == 3'b000,
        tag, {got, s0}, 9'b110001000);
  endtask

  // one full operation; request driven at a negedge in idle
  task automatic do_cycle(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                          input logic [7:0] din, input logic keep_valid);
    logic rd_kind, io_kind;
    logic [7:0] lo, hi;
    rd_kind = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
    io_kind = (k == 3'd3) || (k == 3'd4);
    lo = a[7:0];
    hi = io_kind ? a[7:0] : a[15:8];
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    @(negedge clk); // T1
    chk(ale && ad_oe && rd_n && wr_n && !req_ready, "R2 T1 controls", {ale, ad_oe, rd_n, wr_n, req_ready}, 5'b11110);
    chk(ad_out == lo, "R2 low address", ad_out, lo);
    chk(addr_hi == hi, io_kind ? "R9 port on high byte" : "R2 high address", addr_hi, hi);
    if (io_kind) chk(ad_out == a[7:0], "R9 port on low byte", ad_out, a[7:0]);
    chk({io_m, s1, s0} == exp_status(k), "R3 status in T1", {io_m, s1, s0}, exp_status(k));
    req_valid = 1'b0;
    @(negedge clk); // T2
    ad_in = din;
    chk(!ale, "R2 ale low in T2", ale, 0);
    if (rd_kind) chk(!rd_n && wr_n && !ad_oe, "R4 read T2", {rd_n, wr_n, ad_oe}, 3'b010);
    else         chk(rd_n && !wr_n && ad_oe && ad_out == wd, "R5 write T2", {rd_n, wr_n, ad_oe, ad_out}, {3'b101, wd});
    chk({io_m, s1, s0} == exp_status(k), "R3 status in T2", {io_m, s1, s0}, exp_status(k));
    if (keep_valid) req_valid = 1'b1;
    @(negedge clk); // T3
    if (rd_kind) chk(!rd_n && wr_n && !ad_oe, "R4 read T3", {rd_n, wr_n, ad_oe}, 3'b010);
    else         chk(rd_n && !wr_n && ad_oe && ad_out == wd, "R5 write T3", {rd_n, wr_n, ad_oe, ad_out}, {3'b101, wd});
    chk(done == (k != 3'd0), "R8 done in T3", done, (k != 3'd0));
    chk({io_m, s1, s0} == exp_status(k), "R3 status in T3", {io_m, s1, s0}, exp_status(k));
    @(negedge clk);
    if (k == 3'd0) begin // T4
      chk(done && rd_n && wr_n && !ad_oe, "R7 fetch T4 quiet", {done, rd_n, wr_n, ad_oe}, 4'b1110);
      chk(instr == din && rdata == din, "R6 fetch capture", {instr, rdata}, {din, din});
      last_instr = din;
      @(negedge clk);
    end else begin
      if (rd_kind) chk(rdata == din, "R6 read capture", rdata, din);
      chk(instr == last_instr, "R6 instr kept", instr, last_instr);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; req_valid = 1'b0; req_kind = 3'd0; req_addr = 16'h0; req_wdata = 8'h0; ad_in = 8'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 reset state");
  endtask

  task automatic t_fetch;   do_cycle(3'd0, 16'h1234, 8'h00, 8'h3E, 1'b0); check_idle("R1 idle after fetch"); endtask
  task automatic t_mread;   do_cycle(3'd1, 16'hABCD, 8'h00, 8'h5A, 1'b0); check_idle("R8 idle after read"); endtask
  task automatic t_mwrite;  do_cycle(3'd2, 16'h8001, 8'hC3, 8'h77, 1'b0); chk(rdata == 8'h5A, "R6 write leaves rdata", rdata, 8'h5A); endtask
  task automatic t_ioread;  do_cycle(3'd3, 16'hEE47, 8'h00, 8'hA5, 1'b0); endtask
  task automatic t_iowrite; do_cycle(3'd4, 16'h339F, 8'h11, 8'h00, 1'b0); endtask

  task automatic t_back_to_back;
    // request raised in T2 stays up into T3 (done) and is taken there
    do_cycle(3'd1, 16'h2000, 8'h00, 8'h42, 1'b1);
    // do_cycle already advanced one negedge: we are now in the new T1
    chk(ale && !req_ready, "R10 back-to-back fresh T1", {ale, req_ready}, 2'b10);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk);
    check_idle("R10 back-to-back ends idle");
  endtask

  task automatic t_ignored_mid;
    req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h4444; req_wdata = 8'h99;
    @(negedge clk); // T1, now offer a different request during T1/T2 only
    req_kind = 3'd3; req_addr = 16'h0055;
    @(negedge clk); // T2
    chk(!req_ready, "R10 not ready in T2", req_ready, 0);
    chk(!wr_n && ad_out == 8'h99, "R10 mid request ignored", {wr_n, ad_out}, {1'b0, 8'h99});
    req_valid = 1'b0;
    @(negedge clk); // T3
    @(negedge clk);
    check_idle("R10 no cycle from mid request");
  endtask

  task automatic t_bad_kind;
    for (int k = 5; k < 8; k++) begin
      req_valid = 1'b1; req_kind = k[2:0]; req_addr = 16'h7777;
      @(negedge clk);
      chk(!ale && !ad_oe && rd_n && wr_n, "R11 bad kind ignored", {ale, ad_oe}, 2'b00);
    end
    req_valid = 1'b0;
    @(negedge clk);
    check_idle("R11 idle after bad kinds");
  endtask

  task automatic t_reset_mid;
    req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h1111; req_wdata = 8'h22;
    @(negedge clk); // T1
    req_valid = 1'b0;
    @(negedge clk); // T2
    rst = 1'b1;
    @(negedge clk);
    chk(rd_n && wr_n && !ale && !ad_oe && !done, "R12 reset mid cycle", {rd_n, wr_n, ale, ad_oe, done}, 5'b11000);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R12 idle after reset");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_fetch();
        t_mread();
        t_mwrite();
        t_ioread();
        t_iowrite();
        t_back_to_back();
        t_ignored_mid();
        t_bad_kind();
        t_reset_mid();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule